// File: doc/BRIEF.md
# PPS-Synchronized Timestamp Counter

The block keeps a free-running cycle counter in the fast system clock domain. That clock runs at twice the shared reference frequency. The counter gives a time base to two capture paths. An external one-pulse-per-second (PPS) input is synchronized and edge-detected. On each rising edge the block either samples the counter into a PPS sample register or, when a one-shot resync has been armed, clears the counter to zero. Boards that share the same reference and are resynchronized on the same PPS edge then record identical PPS samples. Comparing those samples across boards exposes timing faults.

A second, synchronous event strobe marks the capture or generation of a timing waveform on the communication path. It latches the counter into an event timestamp register. Software reads both samples, their valid and overrun flags, and the resync state through a small word-wide register read port.

Top module: `pps_timestamp`

## Requirements
- R1: The counter advances by one on every clock cycle and wraps from its all-ones value to zero. Two event captures taken N cycles apart therefore differ by N.
- R2: `pps_i` passes through a two-flop synchronizer and only its rising edge is acted on. A PPS level held high for many cycles causes exactly one action.
- R3: With resync not armed, a PPS rising edge copies the current counter value into the PPS sample register, readable at address 1 (low word) and address 2 (high word).
- R4: `arm_i` arms a one-shot resync (status bit 4). The next PPS rising edge takes no PPS sample. The counter reads zero in the following cycle, the arm bit self-clears and the resync-done flag (status bit 5) is set.
- R5: A one-cycle `evt_i` pulse latches the counter value of that cycle into the event register, readable at address 3 (low word) and address 4 (high word).
- R6: Each capture sets its valid flag. A capture while valid is still set also sets the overrun flag. Reading the high word of that register (address 2 or 4) clears both flags.
- R7: If `evt_i` and a PPS rising edge fall in the same cycle with resync not armed, both registers capture the same counter value.
- R8: Address 0 returns the status word: bit0 PPS valid, bit1 PPS overrun, bit2 event valid, bit3 event overrun, bit4 armed, bit5 resync done, other bits zero. Addresses 5 to 7 read zero. Counter bits above the counter width read zero.
- R9: After reset the counter, both capture registers and all status flags are zero.
- R10: Pulsing `arm_i` clears the resync-done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pps_i | input | 1 | Asynchronous one-pulse-per-second input |
| evt_i | input | 1 | Synchronous event strobe, one cycle per event |
| arm_i | input | 1 | Single-cycle request to arm the one-shot resync |
| rd_en_i | input | 1 | Read strobe; side effects occur at the clock edge |
| rd_addr_i | input | 3 | Read word address |
| rd_data_o | output | 32 | Read data, combinational from the addressed word |

## Verification
Isolated event strobes separated by a known cycle count tell a counter that advances every cycle from one that skips or stalls. Back-to-back strobes separate plain valid from overrun. A PPS level held high for many cycles shows whether the edge detector acts once or repeats. A PPS edge landing in the same cycle as an event strobe checks that both paths capture the same value, and an armed edge followed at once by a strobe must capture zero. A long random mix of PPS toggles, strobes, arm requests and reads at every address is compared against a cycle model in the bench. A strobe placed right after the all-ones count separates wrapping from saturating.

// File: rtl/pps_ts_pkg.sv
package pps_ts_pkg;
  localparam int RD_W   = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STATUS = 3'd0,
    ADDR_PPS_LO = 3'd1,
    ADDR_PPS_HI = 3'd2,
    ADDR_EVT_LO = 3'd3,
    ADDR_EVT_HI = 3'd4
  } ts_addr_e;

  localparam int ST_PPS_VLD  = 0;
  localparam int ST_PPS_OVR  = 1;
  localparam int ST_EVT_VLD  = 2;
  localparam int ST_EVT_OVR  = 3;
  localparam int ST_ARMED    = 4;
  localparam int ST_RSY_DONE = 5;

  typedef struct packed {
    logic rsy_done;
    logic armed;
    logic evt_ovr;
    logic evt_vld;
    logic pps_ovr;
    logic pps_vld;
  } ts_status_t;
endpackage

// File: rtl/pps_sync_edge.sv
module pps_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= async_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b0;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // a rising edge is never reported on two consecutive cycles
  assert_single_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter int W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  assert_cnt_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_o == W'($past(cnt_o) + W'(1)));

  assert_cnt_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/ts_capture.sv
module ts_capture #(
  parameter int W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] data_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] data_o,
  output logic         vld_o,
  output logic         ovr_o
);
  logic [W-1:0] data_q;
  logic         vld_q, ovr_q;
  logic         vld_d, ovr_d;

  always_comb begin
    vld_d = rd_clr_i ? 1'b0 : vld_q;
    ovr_d = rd_clr_i ? 1'b0 : ovr_q;
    if (cap_i) begin
      ovr_d = ovr_d | vld_d;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      vld_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (cap_i) data_q <= data_i;
      vld_q <= vld_d;
      ovr_q <= ovr_d;
    end
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;
  assign ovr_o  = ovr_q;

  assert_cap_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> vld_o && data_o == $past(data_i));

  assert_cap_overrun_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i && vld_o && !rd_clr_i |=> ovr_o);

  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr_i && !cap_i |=> !vld_o && !ovr_o);
endmodule

// File: rtl/pps_timestamp.sv
module pps_timestamp
  import pps_ts_pkg::*;
#(
  parameter int CNT_W       = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pps_i,
  input  logic              evt_i,
  input  logic              arm_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [RD_W-1:0]   rd_data_o
);
  localparam int PAD_W = 2 * RD_W;

  logic             pps_rise;
  logic [CNT_W-1:0] cnt;
  logic             armed_q, done_q;
  logic             rsy_fire, pps_cap;
  logic             pps_clr, evt_clr;
  logic [CNT_W-1:0] pps_data, evt_data;
  logic             pps_vld, pps_ovr, evt_vld, evt_ovr;
  logic [PAD_W-1:0] pps_pad, evt_pad;
  ts_status_t       status;

  pps_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pps_i),
    .rise_o  (pps_rise)
  );

  assign rsy_fire = pps_rise & armed_q;
  assign pps_cap  = pps_rise & ~armed_q;

  ts_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rsy_fire),
    .cnt_o  (cnt)
  );

  // one-shot resync; a new arm request wins over a same-cycle fire
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (rsy_fire) begin
        armed_q <= 1'b0;
        done_q  <= 1'b1;
      end
      if (arm_i) begin
        armed_q <= 1'b1;
        done_q  <= 1'b0;
      end
    end
  end

  assign pps_clr = rd_en_i && (rd_addr_i == ADDR_PPS_HI);
  assign evt_clr = rd_en_i && (rd_addr_i == ADDR_EVT_HI);

  ts_capture #(.W(CNT_W)) u_pps_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (pps_cap),
    .data_i   (cnt),
    .rd_clr_i (pps_clr),
    .data_o   (pps_data),
    .vld_o    (pps_vld),
    .ovr_o    (pps_ovr)
  );

  ts_capture #(.W(CNT_W)) u_evt_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (evt_i),
    .data_i   (cnt),
    .rd_clr_i (evt_clr),
    .data_o   (evt_data),
    .vld_o    (evt_vld),
    .ovr_o    (evt_ovr)
  );

  always_comb begin
    pps_pad = '0;
    evt_pad = '0;
    pps_pad[CNT_W-1:0] = pps_data;
    evt_pad[CNT_W-1:0] = evt_data;
  end

  assign status = '{rsy_done: done_q, armed: armed_q, evt_ovr: evt_ovr,
                    evt_vld: evt_vld, pps_ovr: pps_ovr, pps_vld: pps_vld};

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_STATUS: rd_data_o[$bits(ts_status_t)-1:0] = status;
      ADDR_PPS_LO: rd_data_o = pps_pad[RD_W-1:0];
      ADDR_PPS_HI: rd_data_o = pps_pad[PAD_W-1:RD_W];
      ADDR_EVT_LO: rd_data_o = evt_pad[RD_W-1:0];
      ADDR_EVT_HI: rd_data_o = evt_pad[PAD_W-1:RD_W];
      default:     rd_data_o = '0;
    endcase
  end

  assert_resync_oneshot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && pps_rise && !arm_i |=> !armed_q && done_q);

  assert_resync_no_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && pps_rise |=> $stable(pps_data));

  assert_same_value_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i && pps_rise && !armed_q |=> pps_data == evt_data);

  assert_arm_clears_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> armed_q && !done_q);
endmodule

// File: tb/pps_timestamp_test.sv
`timescale 1ns/1ps
module pps_timestamp_test;
  localparam int TW = 16;
  localparam logic [TW-1:0] MAXC = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pps_r = 1'b0, evt_r = 1'b0, arm_r = 1'b0, rd_en_r = 1'b0;
  logic [2:0]  rd_addr_r = 3'd0;
  logic [31:0] rd_data;

  int total = 0, failed = 0;
  longint cyc = 0;

  // bench model state
  logic [TW-1:0] m_cnt, m_pps, m_evt;
  logic m_s1, m_s2, m_s3, m_armed, m_done;
  logic m_pv, m_po, m_ev, m_eo;

  always #2.5 clk = ~clk;

  pps_timestamp #(.CNT_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pps_i(pps_r), .evt_i(evt_r), .arm_i(arm_r),
    .rd_en_i(rd_en_r), .rd_addr_i(rd_addr_r), .rd_data_o(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {26'd0, m_done, m_armed, m_eo, m_ev, m_po, m_pv};
      3'd1: return {16'd0, m_pps};
      3'd3: return {16'd0, m_evt};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd1, 3'd2: return "R3";
      3'd3, 3'd4: return "R5";
      default:    return "R8";
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_pps = '0; m_evt = '0;
    m_s1 = 0; m_s2 = 0; m_s3 = 0; m_armed = 0; m_done = 0;
    m_pv = 0; m_po = 0; m_ev = 0; m_eo = 0;
  endtask

  task automatic model_step();
    logic edge_now, pclr, eclr;
    edge_now = m_s2 & ~m_s3;
    pclr = rd_en_r && rd_addr_r == 3'd2;
    eclr = rd_en_r && rd_addr_r == 3'd4;
    if (pclr) begin m_pv = 0; m_po = 0; end
    if (eclr) begin m_ev = 0; m_eo = 0; end
    if (edge_now && !m_armed) begin m_po = m_po | m_pv; m_pv = 1; m_pps = m_cnt; end
    if (evt_r) begin m_eo = m_eo | m_ev; m_ev = 1; m_evt = m_cnt; end
    if (edge_now && m_armed) begin m_cnt = '0; m_armed = 0; m_done = 1; end
    else m_cnt = m_cnt + 1'b1;
    if (arm_r) begin m_armed = 1; m_done = 0; end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = pps_r;
  endtask

  // one clock; entered and left at a falling edge
  task automatic cycle();
    @(posedge clk);
    model_step();
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req,
                    output logic [31:0] got);
    rd_en_r = 1; rd_addr_r = a;
    #1;
    got = rd_data;
    chk(req, got, exp);
    cycle();
    rd_en_r = 0;
  endtask

  task automatic pulse_evt();
    evt_r = 1; cycle(); evt_r = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    logic [31:0] v, a, b;
    longint t1, t2;
    model_reset();
    #12;
    @(negedge clk);
    rst_n = 1;

    // R9: reset state
    for (int i = 0; i < 5; i++) rd(3'(i), 32'd0, "R9", v);

    // R1: strobes N cycles apart differ by N
    t1 = cyc; pulse_evt();
    rd(3'd3, exp_rd(3'd3), "R5", a);
    rd(3'd4, 32'd0, "R5", v);
    idle(7);
    t2 = cyc; pulse_evt();
    rd(3'd3, exp_rd(3'd3), "R5", b);
    chk("R1", b - a, 32'(t2 - t1));
    rd(3'd4, 32'd0, "R5", v);

    // R6: back-to-back strobes -> overrun, hi read clears
    pulse_evt(); pulse_evt();
    rd(3'd0, 32'h0C, "R6", v);
    rd(3'd4, 32'd0, "R6", v);
    rd(3'd0, 32'h00, "R6", v);

    // R2: long high level acts once
    pps_r = 1; idle(20);
    rd(3'd0, 32'h01, "R2", v);
    rd(3'd1, exp_rd(3'd1), "R3", v);
    rd(3'd2, 32'd0, "R3", v);
    pps_r = 0; idle(5);

    // R7: strobe in the PPS edge cycle
    pps_r = 1; idle(2);
    pulse_evt();
    rd(3'd1, exp_rd(3'd1), "R3", a);
    rd(3'd3, exp_rd(3'd3), "R5", b);
    chk("R7", a, b);
    rd(3'd2, 32'd0, "R7", v);
    rd(3'd4, 32'd0, "R7", v);
    pps_r = 0; idle(5);

    // R4: armed edge clears counter, no sample
    arm_r = 1; cycle(); arm_r = 0;
    rd(3'd0, 32'h10, "R4", v);
    pps_r = 1; idle(3);
    pulse_evt();
    rd(3'd3, 32'd0, "R4", v);
    rd(3'd0, 32'h24, "R4", v);
    rd(3'd4, 32'd0, "R4", v);
    pps_r = 0; idle(4);

    // R10: re-arm clears done
    arm_r = 1; cycle(); arm_r = 0;
    rd(3'd0, 32'h10, "R10", v);

    // random mix against the model
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 70000; i++) begin
      if ($urandom_range(299) == 0) pps_r = ~pps_r;
      evt_r = ($urandom_range(39) == 0);
      arm_r = ($urandom_range(1999) == 0);
      rd_en_r = ($urandom_range(2) == 0);
      rd_addr_r = 3'($urandom_range(7));
      #1;
      if (rd_en_r) chk(tag_of(rd_addr_r), rd_data, exp_rd(rd_addr_r));
      cycle();
    end
    evt_r = 0; arm_r = 0; rd_en_r = 0; pps_r = 0;
    idle(4);
    rd(3'd2, 32'd0, "R3", v);

    // R1: wrap from all-ones to zero
    while (m_cnt != MAXC) cycle();
    rd(3'd4, 32'd0, "R5", v);
    pulse_evt();
    rd(3'd3, 32'd0, "R1", v);
    rd(3'd4, 32'd0, "R1", v);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule